// File: doc/BRIEF.md
# Serial Flash Write-Command Front End

This block sits on the slave side of a four-wire SPI bus for a 64 KB serial flash. The four wires are chip select, serial clock, serial in and serial out. It turns each write-type frame into one command for a memory-array controller. A frame starts with an 8-bit opcode, MSB first. Three address bytes follow, also MSB first. Three opcodes are recognised: a 32 KB block erase, a 4 KB block erase and a page program of 1 to 256 bytes. For each accepted command the block reports the aligned first and last address of the affected region. It does this once chip select has risen again.

For page program, the data bytes are collected into a local page buffer while the frame runs. After the command is accepted, the bytes are passed on one per beat, each with its address. The bus pins are brought into the system clock domain through a short synchroniser. Only the rising edge of the serial clock is used for sampling, so the block works with both SPI mode 0 and SPI mode 3.

Two valid/ready streams leave the block: a command stream and a data stream. A beat transfers on a clock edge where both valid and ready are high. While valid is high and ready is low, every field of that stream is held unchanged. A program command is always transferred before any of its data beats, and the two streams are never valid at the same time. While a command or its data is still waiting, the block is busy: it ignores any frame whose chip select falls during that time. The controller therefore sets how soon the next frame may be taken, and no bus frame is ever half-received.

Top module: `spi_flash_cmd_front`

## Requirements
- R1: Serial input is sampled only on rising serial-clock edges while chip select is low. A clock already high when chip select falls (mode 3 idle) is not counted as an edge, so mode 0 and mode 3 frames decode identically.
- R2: Opcode 52h gives a command with cmd_kind = 1, cmd_start equal to the address with bits 14:0 cleared, cmd_end equal to the address with bits 14:0 set, and cmd_len = 0.
- R3: Opcode 20h gives a command with cmd_kind = 2, cmd_start equal to the address with bits 11:0 cleared, cmd_end equal to the address with bits 11:0 set, and cmd_len = 0.
- R4: Opcode 02h with at least one complete data byte gives a command with cmd_kind = 3, cmd_start equal to the page base (bits 7:0 cleared), cmd_end equal to the page base with bits 7:0 set, and cmd_len equal to the number of kept bytes (1 to 256).
- R5: After a program command, the data stream carries the kept bytes in arrival order. dat_addr starts at the received address and increments within the page, wrapping from xxFFh to xx00h. dat_last is high on the final beat only.
- R6: When more than 256 data bytes arrive, only the last 256 are kept. The first beat then carries address (received low byte + byte count) mod 256 within the page.
- R7: An erase frame gives a command only if chip select rises right after the 32nd bit, with no extra bits. A program frame with no complete data byte gives no command. Such frames leave both streams idle.
- R8: Address bits 23:16 have no effect on any output.
- R9: An opcode other than 52h, 20h or 02h produces no command and no data beat, whatever follows it.
- R10: While valid is high and ready is low, valid and all fields of that stream stay stable. Data beats appear only after their command has been accepted.
- R11: A frame whose chip select falls while a command or its data is still pending is ignored entirely.
- R12: The serial output is held low at all times.
- R13: After reset, both stream valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idle low (mode 0) or high (mode 3) |
| spi_si | input | 1 | Serial data from the bus master |
| spi_so | output | 1 | Serial data to the bus master (always low) |
| cmd_valid | output | 1 | Command stream valid |
| cmd_ready | input | 1 | Command stream ready |
| cmd_kind | output | 2 | 1 = 32 KB erase, 2 = 4 KB erase, 3 = page program |
| cmd_start | output | 16 | First address of the affected region |
| cmd_end | output | 16 | Last address of the affected region |
| cmd_len | output | 9 | Data beats to follow (0 for erase) |
| dat_valid | output | 1 | Data stream valid |
| dat_ready | input | 1 | Data stream ready |
| dat_addr | output | 16 | Array address of this data byte |
| dat_byte | output | 8 | Data byte |
| dat_last | output | 1 | Final data beat of the command |

## Verification
A bit counter that slips, or an extra edge taken at a mode 3 chip-select fall, moves every later byte by one bit position. This shows as a missing command or a wrong opcode or address on the command stream a few clocks after chip select rises. A faulty write pointer or page buffer shows only on the data stream, as a wrong dat_addr or dat_byte, starting with the first beat after the command is accepted. A busy flag or handshake fault shows as a spurious or lost command, or as fields that change while ready is held low.

// File: rtl/spi_fcf_pkg.sv
package spi_fcf_pkg;

  typedef enum logic [1:0] {
    K_NONE        = 2'd0,
    K_ERASE_BIG   = 2'd1,
    K_ERASE_SMALL = 2'd2,
    K_PROG        = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_CMD  = 2'd1,
    S_DATA = 2'd2
  } issue_state_e;

endpackage

// File: rtl/spi_fcf_sync.sv
module spi_fcf_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/spi_fcf_frame_rx.sv
module spi_fcf_frame_rx
  import spi_fcf_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter int         PAGE_W   = 8,
  parameter logic [7:0] OP_BIG   = 8'h52,
  parameter logic [7:0] OP_SMALL = 8'h20,
  parameter logic [7:0] OP_PROG  = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              si_i,
  input  logic              busy_i,
  output logic              wr_en_o,
  output logic [PAGE_W-1:0] wr_idx_o,
  output logic [7:0]        wr_byte_o,
  output logic              done_o,
  output op_kind_e          done_kind_o,
  output logic [ADDR_W-1:0] done_addr_o,
  output logic [PAGE_W-1:0] done_first_o,
  output logic [PAGE_W:0]   done_len_o
);

  localparam int            PAGE_BYTES = 1 << PAGE_W;
  localparam logic [PAGE_W:0] LEN_MAX  = (PAGE_W+1)'(PAGE_BYTES);
  localparam logic [2:0]    DATA_IDX   = 3'd4;

  logic              cs_q, sclk_q;
  logic [2:0]        bit_cnt_q, byte_cnt_q;
  logic [6:0]        sh_q;
  op_kind_e          kind_q;
  logic              ignore_q, extra_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PAGE_W-1:0] a0_q, wptr_q;
  logic [PAGE_W:0]   dcnt_q;

  logic       frame_start, frame_end, sclk_rise, live, byte_done, in_data;
  logic [7:0] full;
  op_kind_e   dec_kind;
  logic       erase_ok, prog_ok;

  function automatic op_kind_e decode(input logic [7:0] op);
    if (op == OP_BIG)        return K_ERASE_BIG;
    else if (op == OP_SMALL) return K_ERASE_SMALL;
    else if (op == OP_PROG)  return K_PROG;
    else                     return K_NONE;
  endfunction

  assign frame_start = cs_q & ~cs_n_i;
  assign frame_end   = ~cs_q & cs_n_i;
  // rising edge only, and never in the cycle chip select falls (mode 3 idle high)
  assign sclk_rise   = ~cs_n_i & ~cs_q & sclk_i & ~sclk_q;
  assign live        = sclk_rise & ~ignore_q;
  assign full        = {sh_q, si_i};
  assign byte_done   = live & (bit_cnt_q == 3'd7);
  assign in_data     = (byte_cnt_q == DATA_IDX);
  assign dec_kind    = decode(full);

  assign wr_en_o   = byte_done & in_data & (kind_q == K_PROG);
  assign wr_idx_o  = wptr_q;
  assign wr_byte_o = full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q       <= 1'b1;
      sclk_q     <= 1'b0;
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      sh_q       <= '0;
      kind_q     <= K_NONE;
      ignore_q   <= 1'b1;
      extra_q    <= 1'b0;
      addr_q     <= '0;
      a0_q       <= '0;
      wptr_q     <= '0;
      dcnt_q     <= '0;
    end else begin
      cs_q   <= cs_n_i;
      sclk_q <= sclk_i;
      if (frame_start) begin
        bit_cnt_q  <= '0;
        byte_cnt_q <= '0;
        kind_q     <= K_NONE;
        ignore_q   <= busy_i;
        extra_q    <= 1'b0;
        dcnt_q     <= '0;
      end else if (live) begin
        sh_q      <= full[6:0];
        bit_cnt_q <= bit_cnt_q + 3'd1;
        if (bit_cnt_q == 3'd7) begin
          if (!in_data) byte_cnt_q <= byte_cnt_q + 3'd1;
          case (byte_cnt_q)
            3'd0: begin
              kind_q <= dec_kind;
              if (dec_kind == K_NONE) ignore_q <= 1'b1;
            end
            3'd1, 3'd2: addr_q <= {addr_q[ADDR_W-9:0], full};
            3'd3: begin
              addr_q <= {addr_q[ADDR_W-9:0], full};
              a0_q   <= full[PAGE_W-1:0];
              wptr_q <= full[PAGE_W-1:0];
            end
            default: begin
              if (kind_q == K_PROG) begin
                wptr_q <= wptr_q + 1'b1;
                if (dcnt_q != LEN_MAX) dcnt_q <= dcnt_q + 1'b1;
              end else begin
                extra_q <= 1'b1;
              end
            end
          endcase
        end
      end
    end
  end

  assign erase_ok = ((kind_q == K_ERASE_BIG) || (kind_q == K_ERASE_SMALL)) &&
                    in_data && (bit_cnt_q == 3'd0) && !extra_q;
  assign prog_ok  = (kind_q == K_PROG) && (dcnt_q != '0);

  assign done_o       = frame_end & ~ignore_q & (erase_ok | prog_ok);
  assign done_kind_o  = kind_q;
  assign done_addr_o  = addr_q;
  assign done_first_o = (dcnt_q == LEN_MAX) ? wptr_q : a0_q;
  assign done_len_o   = dcnt_q;

  AST_DONE_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_i); // R11

endmodule

// File: rtl/spi_fcf_page_buf.sv
module spi_fcf_page_buf #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [PAGE_W-1:0] wr_idx_i,
  input  logic [7:0]        wr_byte_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output logic [7:0]        rd_byte_o
);

  localparam int DEPTH = 1 << PAGE_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_idx_i] <= wr_byte_i;
  end

  assign rd_byte_o = mem[rd_idx_i];

endmodule

// File: rtl/spi_fcf_cmd_issue.sv
module spi_fcf_cmd_issue
  import spi_fcf_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int PAGE_W  = 8,
  parameter int BIG_W   = 15,
  parameter int SMALL_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  op_kind_e          kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PAGE_W-1:0] first_i,
  input  logic [PAGE_W:0]   len_i,
  input  logic [7:0]        rd_byte_i,
  output logic [PAGE_W-1:0] rd_idx_o,
  output logic              busy_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [1:0]        cmd_kind_o,
  output logic [ADDR_W-1:0] cmd_start_o,
  output logic [ADDR_W-1:0] cmd_end_o,
  output logic [PAGE_W:0]   cmd_len_o,
  output logic              dat_valid_o,
  input  logic              dat_ready_i,
  output logic [ADDR_W-1:0] dat_addr_o,
  output logic [7:0]        dat_byte_o,
  output logic              dat_last_o
);

  localparam logic [ADDR_W-1:0] BIG_MASK   = ADDR_W'((1 << BIG_W) - 1);
  localparam logic [ADDR_W-1:0] SMALL_MASK = ADDR_W'((1 << SMALL_W) - 1);
  localparam logic [ADDR_W-1:0] PAGE_MASK  = ADDR_W'((1 << PAGE_W) - 1);
  localparam int                PAGE_BYTES = 1 << PAGE_W;

  issue_state_e      state_q;
  op_kind_e          kind_q;
  logic [ADDR_W-1:0] start_q, end_q, mask;
  logic [PAGE_W:0]   len_q, rem_q;
  logic [PAGE_W-1:0] rptr_q;

  always_comb begin
    case (kind_i)
      K_ERASE_BIG:   mask = BIG_MASK;
      K_ERASE_SMALL: mask = SMALL_MASK;
      default:       mask = PAGE_MASK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      kind_q  <= K_NONE;
      start_q <= '0;
      end_q   <= '0;
      len_q   <= '0;
      rem_q   <= '0;
      rptr_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (done_i) begin
          kind_q  <= kind_i;
          start_q <= addr_i & ~mask;
          end_q   <= addr_i | mask;
          len_q   <= (kind_i == K_PROG) ? len_i : '0;
          rem_q   <= len_i;
          rptr_q  <= first_i;
          state_q <= S_CMD;
        end
        S_CMD: if (cmd_ready_i) begin
          state_q <= (kind_q == K_PROG) ? S_DATA : S_IDLE;
        end
        S_DATA: if (dat_ready_i) begin
          rptr_q <= rptr_q + 1'b1;
          rem_q  <= rem_q - 1'b1;
          if (rem_q == (PAGE_W+1)'(1)) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != S_IDLE);
  assign cmd_valid_o = (state_q == S_CMD);
  assign cmd_kind_o  = kind_q;
  assign cmd_start_o = start_q;
  assign cmd_end_o   = end_q;
  assign cmd_len_o   = len_q;
  assign dat_valid_o = (state_q == S_DATA);
  assign dat_addr_o  = {start_q[ADDR_W-1:PAGE_W], rptr_q};
  assign dat_byte_o  = rd_byte_i;
  assign dat_last_o  = (rem_q == (PAGE_W+1)'(1));
  assign rd_idx_o    = rptr_q;

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_start_o) && $stable(cmd_end_o) && $stable(cmd_kind_o) && $stable(cmd_len_o)); // R10
  AST_DAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid_o && !dat_ready_i |=> dat_valid_o && $stable(dat_addr_o) && $stable(dat_byte_o) && $stable(dat_last_o)); // R10
  AST_PROG_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && (kind_q == K_PROG) |-> (cmd_len_o != '0) && (cmd_len_o <= (PAGE_W+1)'(PAGE_BYTES))); // R4
  AST_ERASE_NO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && (kind_q != K_PROG) |-> (cmd_len_o == '0)); // R2
  AST_ONE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid_o && dat_valid_o)); // R10

endmodule

// File: rtl/spi_flash_cmd_front.sv
module spi_flash_cmd_front
  import spi_fcf_pkg::*;
#(
  parameter int         ADDR_W      = 16,
  parameter int         PAGE_W      = 8,
  parameter int         BIG_W       = 15,
  parameter int         SMALL_W     = 12,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] OP_BIG      = 8'h52,
  parameter logic [7:0] OP_SMALL    = 8'h20,
  parameter logic [7:0] OP_PROG     = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_si,
  output logic              spi_so,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_kind,
  output logic [ADDR_W-1:0] cmd_start,
  output logic [ADDR_W-1:0] cmd_end,
  output logic [PAGE_W:0]   cmd_len,
  output logic              dat_valid,
  input  logic              dat_ready,
  output logic [ADDR_W-1:0] dat_addr,
  output logic [7:0]        dat_byte,
  output logic              dat_last
);

  logic [2:0]        pins_s;
  logic              busy, wr_en, done;
  logic [PAGE_W-1:0] wr_idx, rd_idx, done_first;
  logic [7:0]        wr_byte, rd_byte;
  op_kind_e          done_kind;
  logic [ADDR_W-1:0] done_addr;
  logic [PAGE_W:0]   done_len;

  // bit 0 chip select (idles high), bit 1 clock, bit 2 data
  spi_fcf_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({spi_si, spi_sclk, spi_cs_n}),
    .dout (pins_s)
  );

  spi_fcf_frame_rx #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
    .OP_BIG(OP_BIG), .OP_SMALL(OP_SMALL), .OP_PROG(OP_PROG)
  ) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_i      (pins_s[0]),
    .sclk_i      (pins_s[1]),
    .si_i        (pins_s[2]),
    .busy_i      (busy),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx),
    .wr_byte_o   (wr_byte),
    .done_o      (done),
    .done_kind_o (done_kind),
    .done_addr_o (done_addr),
    .done_first_o(done_first),
    .done_len_o  (done_len)
  );

  spi_fcf_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk      (clk),
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_idx),
    .wr_byte_i(wr_byte),
    .rd_idx_i (rd_idx),
    .rd_byte_o(rd_byte)
  );

  spi_fcf_cmd_issue #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BIG_W(BIG_W), .SMALL_W(SMALL_W)
  ) u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_i     (done),
    .kind_i     (done_kind),
    .addr_i     (done_addr),
    .first_i    (done_first),
    .len_i      (done_len),
    .rd_byte_i  (rd_byte),
    .rd_idx_o   (rd_idx),
    .busy_o     (busy),
    .cmd_valid_o(cmd_valid),
    .cmd_ready_i(cmd_ready),
    .cmd_kind_o (cmd_kind),
    .cmd_start_o(cmd_start),
    .cmd_end_o  (cmd_end),
    .cmd_len_o  (cmd_len),
    .dat_valid_o(dat_valid),
    .dat_ready_i(dat_ready),
    .dat_addr_o (dat_addr),
    .dat_byte_o (dat_byte),
    .dat_last_o (dat_last)
  );

  assign spi_so = 1'b0;

  AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_kind == 2'd2) |-> (cmd_start[SMALL_W-1:0] == '0) && (&cmd_end[SMALL_W-1:0])); // R3
  AST_DATA_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid |-> (dat_addr >= cmd_start) && (dat_addr <= cmd_end)); // R5

endmodule

// File: tb/spi_flash_cmd_front_test.sv
module spi_flash_cmd_front_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_si = 1'b0;
  logic spi_so;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [1:0]  cmd_kind;
  logic [15:0] cmd_start, cmd_end;
  logic [8:0]  cmd_len;
  logic dat_valid, dat_ready = 1'b0;
  logic [15:0] dat_addr;
  logic [7:0]  dat_byte;
  logic dat_last;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] fb [0:319];
  int fb_n;

  always #2 clk = ~clk;

  spi_flash_cmd_front uut (
    .clk(clk), .rst_n(rst_n),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_si(spi_si), .spi_so(spi_so),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_start(cmd_start), .cmd_end(cmd_end), .cmd_len(cmd_len),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_addr(dat_addr),
    .dat_byte(dat_byte), .dat_last(dat_last)
  );

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    spi_sclk = 1'b0;
    spi_si   = b;
    repeat (4) @(negedge clk);
    spi_sclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input bit m3, input int extra_bits);
    spi_sclk = m3;
    repeat (4) @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < fb_n; i++)
      for (int k = 7; k >= 0; k--) send_bit(fb[i][k]);
    for (int e = 0; e < extra_bits; e++) send_bit(1'b1);
    if (!m3) spi_sclk = 1'b0;
    repeat (4) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic set_hdr(input logic [7:0] op, input logic [23:0] a);
    fb[0] = op; fb[1] = a[23:16]; fb[2] = a[15:8]; fb[3] = a[7:0];
    fb_n = 4;
  endtask

  function automatic logic [7:0] pay(input int idx, input int seed);
    return 8'((idx * 7 + seed) & 255);
  endfunction

  task automatic add_payload(input int n, input int seed);
    for (int i = 0; i < n; i++) fb[4 + i] = pay(i, seed);
    fb_n = 4 + n;
  endtask

  task automatic expect_cmd(input string tag, input logic [1:0] kind, input logic [15:0] st,
                            input logic [15:0] en, input logic [8:0] len, input int hold);
    int t = 0;
    logic [49:0] snap;
    bit stable_ok = 1'b1;
    while (!cmd_valid && t < 300) begin @(negedge clk); t++; end
    check_eq({tag, " cmd_valid"}, 32'(cmd_valid), 32'd1);
    check_eq({tag, " R10 no data before cmd"}, 32'(dat_valid), 32'd0);
    if (hold > 0) begin
      snap = {cmd_kind, cmd_start, cmd_end, cmd_len, cmd_valid};
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        if ({cmd_kind, cmd_start, cmd_end, cmd_len, cmd_valid} !== snap) stable_ok = 1'b0;
      end
      check_eq({tag, " R10 cmd held under back-pressure"}, 32'(stable_ok), 32'd1);
    end
    check_eq({tag, " kind"}, 32'(cmd_kind), 32'(kind));
    check_eq({tag, " start"}, 32'(cmd_start), 32'(st));
    check_eq({tag, " end"}, 32'(cmd_end), 32'(en));
    check_eq({tag, " len"}, 32'(cmd_len), 32'(len));
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
  endtask

  task automatic expect_data(input string tag, input logic [15:0] page, input int a0,
                             input int n, input int seed, input int stall);
    int len = (n > 256) ? 256 : n;
    int bad = 0;
    for (int j = 0; j < len; j++) begin
      int idx = n - len + j;
      logic [15:0] ea = page | 16'((a0 + idx) & 255);
      int t = 0;
      logic [15:0] sa;
      while (!dat_valid && t < 300) begin @(negedge clk); t++; end
      sa = dat_addr;
      if (stall > 0) begin
        repeat (stall) @(negedge clk);
        if (!dat_valid || dat_addr !== sa) bad++;
      end
      if (!dat_valid || dat_addr !== ea || dat_byte !== pay(idx, seed) ||
          dat_last !== (j == len - 1)) begin
        if (bad < 4)
          $display("FAIL %s beat %0d: actual=%0h/%0h/%0b expected=%0h/%0h/%0b", tag, j,
                   dat_addr, dat_byte, dat_last, ea, pay(idx, seed), (j == len - 1));
        bad++;
      end
      dat_ready = 1'b1;
      @(negedge clk);
      dat_ready = 1'b0;
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  task automatic expect_none(input string tag, input int cycles);
    bit seen = 1'b0;
    bit so_hi = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (cmd_valid || dat_valid) seen = 1'b1;
      if (spi_so !== 1'b0) so_hi = 1'b1;
    end
    check_eq({tag, " no output"}, 32'(seen), 32'd0);
    check_eq({tag, " R12 so low"}, 32'(so_hi), 32'd0);
  endtask

  task automatic t_reset;
    check_eq("R13 cmd_valid after reset", 32'(cmd_valid), 32'd0);
    check_eq("R13 dat_valid after reset", 32'(dat_valid), 32'd0);
    check_eq("R12 so after reset", 32'(spi_so), 32'd0);
  endtask

  task automatic t_erase_big;
    set_hdr(8'h52, 24'h009ABC); send_frame(1'b0, 0);
    expect_cmd("R2 mode0", 2'd1, 16'h8000, 16'hFFFF, 9'd0, 0);
    set_hdr(8'h52, 24'h123456); send_frame(1'b1, 0);
    expect_cmd("R2 R8 R1 mode3", 2'd1, 16'h0000, 16'h7FFF, 9'd0, 0);
    expect_none("R2 single", 20);
  endtask

  task automatic t_erase_small;
    set_hdr(8'h20, 24'hFFD123); send_frame(1'b1, 0);
    expect_cmd("R3 R8 R1 mode3", 2'd2, 16'hD000, 16'hDFFF, 9'd0, 0);
    set_hdr(8'h20, 24'h000FFF); send_frame(1'b0, 0);
    expect_cmd("R3 mode0", 2'd2, 16'h0000, 16'h0FFF, 9'd0, 0);
  endtask

  task automatic t_program;
    set_hdr(8'h02, 24'h004A10); add_payload(5, 3); send_frame(1'b0, 0);
    expect_cmd("R4 prog", 2'd3, 16'h4A00, 16'h4AFF, 9'd5, 0);
    expect_data("R5 prog data", 16'h4A00, 8'h10, 5, 3, 0);
    set_hdr(8'h02, 24'h0003FE); add_payload(4, 90); send_frame(1'b1, 3);
    expect_cmd("R4 R1 prog wrap", 2'd3, 16'h0300, 16'h03FF, 9'd4, 0);
    expect_data("R5 wrap data", 16'h0300, 8'hFE, 4, 90, 2);
    expect_none("R5 after data", 20);
  endtask

  task automatic t_overflow;
    set_hdr(8'h02, 24'h000510); add_payload(300, 11); send_frame(1'b0, 0);
    expect_cmd("R6 over", 2'd3, 16'h0500, 16'h05FF, 9'd256, 0);
    expect_data("R6 last 256", 16'h0500, 8'h10, 300, 11, 0);
  endtask

  task automatic t_bad_frames;
    set_hdr(8'h20, 24'h001000); send_frame(1'b0, 3);
    expect_none("R7 erase extra bits", 40);
    set_hdr(8'h52, 24'h001000); fb[4] = 8'h00; fb_n = 5; send_frame(1'b1, 0);
    expect_none("R7 erase extra byte", 40);
    set_hdr(8'h20, 24'h001000); fb_n = 3; send_frame(1'b0, 0);
    expect_none("R7 erase short", 40);
    set_hdr(8'h02, 24'h001000); send_frame(1'b0, 5);
    expect_none("R7 prog no data", 40);
    set_hdr(8'h03, 24'h001000); add_payload(3, 1); send_frame(1'b0, 0);
    expect_none("R9 unknown opcode", 40);
    set_hdr(8'hD8, 24'h001000); send_frame(1'b1, 0);
    expect_none("R9 unknown opcode mode3", 40);
  endtask

  task automatic t_backpressure;
    set_hdr(8'h20, 24'h00A555); send_frame(1'b0, 0);
    expect_cmd("R10 hold cmd", 2'd2, 16'hA000, 16'hAFFF, 9'd0, 12);
  endtask

  task automatic t_busy;
    set_hdr(8'h02, 24'h00C020); add_payload(2, 50); send_frame(1'b0, 0);
    set_hdr(8'h52, 24'h000000); send_frame(1'b1, 0);
    expect_cmd("R11 pending prog", 2'd3, 16'hC000, 16'hC0FF, 9'd2, 0);
    expect_data("R11 pending data", 16'hC000, 8'h20, 2, 50, 0);
    expect_none("R11 ignored frame", 60);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_erase_big();
    t_erase_small();
    t_program();
    t_overflow();
    t_bad_frames();
    t_backpressure();
    t_busy();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule